// File: doc/BRIEF.md
# Byte-Fed Configurable CRC Engine

A register-mapped CRC calculator for a small processor bus. Software writes one byte at a time into a data register, and each byte is folded into a running 16-bit CRC in a single clock. A control register picks one of three generator polynomials and sets the bit order. The bit order is either reflected, where the least significant bit of each byte enters first, or normal, where the most significant bit enters first. A clear bit in the control register zeroes the running value.

With the 8-bit polynomial, the CRC sits in the low byte of the result and the high byte reads zero. Software can write the result register directly to preload a starting value, either as a whole word or high byte only. When the CRC bytes are fed back through the engine after the data, in transmission order, an error-free message leaves a zero residue.

Top module: `crc_byte_engine`

## Requirements
- R1: After reset, the result is 0x0000, the control register reads 0x00 and the last-data register reads 0x00.
- R2: A write to address 0 stores wdata bits 1:0 as the polynomial select and bit 2 as the order (0 = LSB-first, 1 = MSB-first). Reading address 0 returns those three bits and zero in every other bit, including the clear bit 7.
- R3: A write to address 0 with bit 7 set makes the result 0x0000 on the following cycle.
- R4: A write to address 1 folds wdata[7:0] into the result. The updated value can be read on the next cycle.
- R5: Select 11 uses x^16+x^12+x^5+1. In LSB-first order from 0x0000, the byte 0xF0 gives 0xF78F.
- R6: Select 10 uses x^16+x^15+x^2+1. In LSB-first order from zero, the bytes "123456789" give 0xBB3D.
- R7: Select 01 and select 00 both use x^8+x^2+x+1 with an 8-bit CRC held in the result's low byte. The high byte becomes zero on every data write. In MSB-first order from zero, "123456789" gives 0xF4.
- R8: MSB-first order with select 11 from zero gives 0x31C3 for "123456789".
- R9: Feeding the CRC back after the data leaves 0x0000. In LSB-first order the low byte goes first. In MSB-first order the high byte goes first. In 8-bit mode the single CRC byte is fed.
- R10: A write to address 2 loads all 16 result bits from wdata. A write to address 3 loads only result bits 15:8 from wdata[7:0]. With 0xFFFF preloaded and MSB-first select 11, "123456789" gives 0x29B1.
- R11: The result keeps its value on any cycle with no write, whatever the address.
- R12: rdata_o returns, by address: 0 gives {13'b0, control}, 1 gives {8'b0, last data byte}, 2 gives the result, 3 gives {8'b0, result[15:8]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |

## Verification
On every cycle, the assertions check five things. A clear empties the result, and a word write loads the result exactly. An idle cycle leaves the result untouched, 8-bit mode keeps the high byte at zero, and the control readback never shows the clear bit. The polynomial arithmetic is compared against a serial bit-level reference model in the bench. The bench scenarios cover the known check values, the zero-residue property in each order and width, and preloading.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;
  localparam int CRC_W  = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    SEL_C8A = 2'b00,
    SEL_C8  = 2'b01,
    SEL_A16 = 2'b10,
    SEL_C16 = 2'b11
  } poly_sel_e;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_DIN  = 2'd1,
    REG_RES  = 2'd2,
    REG_RESH = 2'd3
  } reg_addr_e;

  localparam logic [CRC_W-1:0]  POLY_C16 = 16'h1021;
  localparam logic [CRC_W-1:0]  POLY_A16 = 16'h8005;
  localparam logic [BYTE_W-1:0] POLY_C8  = 8'h07;

  function automatic logic [CRC_W-1:0] rev16(input logic [CRC_W-1:0] v);
    for (int i = 0; i < CRC_W; i++) rev16[i] = v[CRC_W-1-i];
  endfunction

  function automatic logic [BYTE_W-1:0] rev8(input logic [BYTE_W-1:0] v);
    for (int i = 0; i < BYTE_W; i++) rev8[i] = v[BYTE_W-1-i];
  endfunction
endpackage

// File: rtl/crc_poly_sel.sv
module crc_poly_sel
  import crc_eng_pkg::*;
(
  input  logic [1:0]        sel_i,
  input  logic              msb_first_i,
  output logic [CRC_W-1:0]  poly16_o,
  output logic [BYTE_W-1:0] poly8_o,
  output logic              narrow_o
);
  logic [CRC_W-1:0] base16;

  always_comb begin
    unique case (poly_sel_e'(sel_i))
      SEL_A16: base16 = POLY_A16;
      default: base16 = POLY_C16;
    endcase
  end

  assign narrow_o = (sel_i == SEL_C8) || (sel_i == SEL_C8A);
  assign poly16_o = msb_first_i ? base16 : rev16(base16);
  assign poly8_o  = msb_first_i ? POLY_C8 : rev8(POLY_C8);
endmodule

// File: rtl/crc_byte_fold.sv
module crc_byte_fold #(
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic [CW-1:0] crc_i,
  input  logic [DW-1:0] data_i,
  input  logic [CW-1:0] poly_i,
  input  logic          reflect_i,
  output logic [CW-1:0] crc_o
);
  localparam int PAD = CW - DW;

  logic [DW:0][CW-1:0] st;

  // byte enters at the end that shifts out first
  assign st[0] = reflect_i ? (crc_i ^ CW'(data_i))
                           : (crc_i ^ (CW'(data_i) << PAD));

  for (genvar g = 0; g < DW; g++) begin : g_step
    assign st[g+1] = reflect_i
      ? ((st[g] >> 1) ^ (st[g][0]    ? poly_i : '0))
      : ((st[g] << 1) ^ (st[g][CW-1] ? poly_i : '0));
  end

  assign crc_o = st[DW];
endmodule

// File: rtl/crc_byte_engine.sv
module crc_byte_engine
  import crc_eng_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CRC_W-1:0]  wdata_i,
  output logic [CRC_W-1:0]  rdata_o
);
  localparam int CTRL_W  = 3;
  localparam int CLR_BIT = 7;
  localparam int HI_W    = CRC_W - BYTE_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [BYTE_W-1:0] din_q;
  logic [CRC_W-1:0]  res_q;

  logic [CRC_W-1:0]  poly16;
  logic [BYTE_W-1:0] poly8;
  logic              narrow;
  logic [CRC_W-1:0]  fold16;
  logic [BYTE_W-1:0] fold8;
  logic [CRC_W-1:0]  res_next;

  crc_poly_sel u_sel (
    .sel_i       (ctrl_q[1:0]),
    .msb_first_i (ctrl_q[2]),
    .poly16_o    (poly16),
    .poly8_o     (poly8),
    .narrow_o    (narrow)
  );

  crc_byte_fold #(.CW(CRC_W), .DW(BYTE_W)) u_fold16 (
    .crc_i     (res_q),
    .data_i    (wdata_i[BYTE_W-1:0]),
    .poly_i    (poly16),
    .reflect_i (~ctrl_q[2]),
    .crc_o     (fold16)
  );

  crc_byte_fold #(.CW(BYTE_W), .DW(BYTE_W)) u_fold8 (
    .crc_i     (res_q[BYTE_W-1:0]),
    .data_i    (wdata_i[BYTE_W-1:0]),
    .poly_i    (poly8),
    .reflect_i (~ctrl_q[2]),
    .crc_o     (fold8)
  );

  assign res_next = narrow ? {{HI_W{1'b0}}, fold8} : fold16;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      din_q  <= '0;
      res_q  <= '0;
    end else if (wr_en_i) begin
      unique case (reg_addr_e'(addr_i))
        REG_CTRL: begin
          ctrl_q <= wdata_i[CTRL_W-1:0];
          if (wdata_i[CLR_BIT]) res_q <= '0;
        end
        REG_DIN: begin
          din_q <= wdata_i[BYTE_W-1:0];
          res_q <= res_next;
        end
        REG_RES:  res_q <= wdata_i;
        REG_RESH: res_q[CRC_W-1:BYTE_W] <= wdata_i[BYTE_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      REG_CTRL: rdata_o = CRC_W'(ctrl_q);
      REG_DIN:  rdata_o = CRC_W'(din_q);
      REG_RES:  rdata_o = res_q;
      REG_RESH: rdata_o = CRC_W'(res_q[CRC_W-1:BYTE_W]);
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/crc_byte_engine_chk.sv
module crc_byte_engine_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [1:0]  addr_i,
  input logic [15:0] wdata_i,
  input logic [15:0] rdata_o,
  input logic [15:0] res_q,
  input logic [2:0]  ctrl_q
);
  a_r3_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd0 && wdata_i[7]) |=> (res_q == 16'h0000));

  a_r10_word_preload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd2) |=> (res_q == $past(wdata_i)));

  a_r11_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(res_q));

  a_r7_narrow_high_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd1 && !ctrl_q[1]) |=> (res_q[15:8] == 8'h00));

  a_r2_ctrl_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd0) |-> (rdata_o[15:3] == 13'h0000));
endmodule

bind crc_byte_engine crc_byte_engine_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .res_q   (res_q),
  .ctrl_q  (ctrl_q)
);

// File: tb/crc_byte_engine_bench.sv
`timescale 1ns/1ps
module crc_byte_engine_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = 2'd2;
  logic [15:0] wdata_i = 16'h0;
  logic [15:0] rdata_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  crc_byte_engine u_crc_byte_engine (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o
  );

  // reference model: serial bit feed, generator in normal form
  logic [2:0]  m_ctrl;
  logic [7:0]  m_din;
  logic [15:0] m_res;

  function automatic logic [15:0] m_fold(input logic [15:0] r0, input logic [7:0] b,
                                         input logic [2:0] cfg);
    int w, poly, rp, r, fb;
    bit narrow;
    narrow = (cfg[1] == 1'b0);
    w = narrow ? 8 : 16;
    poly = narrow ? 'h07 : (cfg[1:0] == 2'b10 ? 'h8005 : 'h1021);
    rp = 0;
    for (int k = 0; k < w; k++) if (poly & (1 << k)) rp |= 1 << (w - 1 - k);
    r = int'(r0) & ((1 << w) - 1);
    if (cfg[2]) begin
      for (int i = 7; i >= 0; i--) begin
        fb = ((r >> (w - 1)) & 1) ^ int'(b[i]);
        r = (r << 1) & ((1 << w) - 1);
        if (fb != 0) r ^= poly;
      end
    end else begin
      for (int i = 0; i < 8; i++) begin
        fb = (r & 1) ^ int'(b[i]);
        r = r >> 1;
        if (fb != 0) r ^= rp;
      end
    end
    return 16'(r);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ctrl = 3'd0; m_din = 8'd0; m_res = 16'd0;
    end else if (wr_en_i) begin
      case (addr_i)
        2'd0: begin m_ctrl = wdata_i[2:0]; if (wdata_i[7]) m_res = 16'd0; end
        2'd1: begin m_res = m_fold(m_res, wdata_i[7:0], m_ctrl); m_din = wdata_i[7:0]; end
        2'd2: m_res = wdata_i;
        default: m_res[15:8] = wdata_i[7:0];
      endcase
    end
  end

  function automatic logic [15:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {13'd0, m_ctrl};
      2'd1: return {8'd0, m_din};
      2'd2: return m_res;
      default: return {8'd0, m_res[15:8]};
    endcase
  endfunction

  // per-cycle comparison, sampled a quarter period after the rising edge (R12)
  always @(posedge clk_i) begin
    #5;
    if (rst_ni && !done) begin
      n_run++;
      if (rdata_o !== m_read(addr_i)) begin
        n_fail++;
        $display("FAIL R12 model compare addr=%0d actual=%h expected=%h",
                 addr_i, rdata_o, m_read(addr_i));
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; addr_i = 2'd2;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic feed_check_str();
    logic [7:0] s [9] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    foreach (s[i]) wr(2'd1, {8'h00, s[i]});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(2'd2, v); chk("R1 result after reset", v, 16'h0000);
    rd(2'd0, v); chk("R1 ctrl after reset", v, 16'h0000);
    rd(2'd1, v); chk("R1 data after reset", v, 16'h0000);

    // LSB-first CCITT
    wr(2'd2, 16'h5A5A);
    wr(2'd0, 16'h0083);
    rd(2'd0, v); chk("R2 ctrl readback clear bit low", v, 16'h0003);
    rd(2'd2, v); chk("R3 clear zeroes result", v, 16'h0000);
    wr(2'd1, 16'h00F0);
    rd(2'd2, v); chk("R4 R5 0xF0 -> 0xF78F", v, 16'hF78F);
    rd(2'd1, v); chk("R12 last data byte", v, 16'h00F0);
    rd(2'd3, v); chk("R12 high byte read", v, 16'h00F7);
    wr(2'd1, 16'h008F); wr(2'd1, 16'h00F7);
    rd(2'd2, v); chk("R9 LSB-first residue", v, 16'h0000);

    // MSB-first CCITT
    wr(2'd0, 16'h0087);
    feed_check_str();
    rd(2'd2, v); chk("R8 MSB-first check value", v, 16'h31C3);
    wr(2'd1, 16'h0031); wr(2'd1, 16'h00C3);
    rd(2'd2, v); chk("R9 MSB-first residue", v, 16'h0000);

    // x16+x15+x2+1 LSB-first
    wr(2'd0, 16'h0082);
    feed_check_str();
    rd(2'd2, v); chk("R6 sel 10 check value", v, 16'hBB3D);
    wr(2'd1, 16'h003D); wr(2'd1, 16'h00BB);
    rd(2'd2, v); chk("R9 sel 10 residue", v, 16'h0000);

    // 8-bit, sel 01 and 00, preloaded high byte must drop
    wr(2'd0, 16'h0085);
    wr(2'd3, 16'h00AB);
    feed_check_str();
    rd(2'd2, v); chk("R7 sel 01 check value", v, 16'h00F4);
    wr(2'd1, 16'h00F4);
    rd(2'd2, v); chk("R9 8-bit residue", v, 16'h0000);
    wr(2'd0, 16'h0084);
    feed_check_str();
    rd(2'd2, v); chk("R7 sel 00 same as 01", v, 16'h00F4);
    rd(2'd3, v); chk("R7 high byte zero", v, 16'h0000);
    wr(2'd0, 16'h0081);
    feed_check_str();

    // preload
    wr(2'd0, 16'h0007);
    wr(2'd2, 16'hFFFF);
    rd(2'd2, v); chk("R10 word preload", v, 16'hFFFF);
    feed_check_str();
    rd(2'd2, v); chk("R10 preloaded check value", v, 16'h29B1);
    wr(2'd3, 16'hFF12);
    rd(2'd2, v); chk("R10 high byte write", v, 16'h12B1);
    wr(2'd0, 16'h0007);
    rd(2'd2, v); chk("R3 no clear keeps result", v, 16'h12B1);

    // idle cycles with address sweep
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i); addr_i = 2'(i);
    end
    rd(2'd2, v); chk("R11 idle hold", v, 16'h12B1);
    wr(2'd0, 16'h00FF);
    rd(2'd0, v); chk("R2 other bits read zero", v, 16'h0007);

    @(negedge clk_i);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule